// File: doc/BRIEF.md
# Cipher Data FIFO Staging Controller

This block stands between a 32-bit register bus and a block-cipher core. Bus writes to the data-in address go into an 8-word input FIFO. Bus reads of the data-out address take words from an 8-word result FIFO. The block decides when the core may begin a block. It then streams the block's input words to the core over a valid/ready channel and accepts the same number of result words back over a second valid/ready channel.

A control word sets the enable bit and the block width: 64-bit blocks are 2 words and 128-bit blocks are 4 words. The same control word carries a flush bit that clears itself. When the block is disabled and idle, software can drain the input FIFO through the data-in address. After such a drain, nothing is processed until a flush has been done.

On the core channels the core may hold `cin_ready` low for as long as it likes. `cin_valid` and its data then stay unchanged. The block raises `cout_ready` only while result words are still owed for the current block. Space for all of those words was reserved in the result FIFO when the block started, so a result word is never refused once `cout_ready` is high.

Top module: `cdf_stage`

## Requirements
- R1: After reset both FIFOs are empty, the full flags, `busy`, both error flags and `bus_rdata` are 0, and the block is disabled in 64-bit mode.
- R2: A bus write to address 0 pushes `bus_wdata` into the input FIFO. `in_full` is 1 when the FIFO holds 8 words and `in_empty` is 1 when it holds none.
- R3: A write to address 0 while the input FIFO is full is dropped and sets `err_ovf`. `err_ovf` stays set until a flush.
- R4: The control word is written at address 2: bit 0 is enable and bit 1 is mode (1 = 4-word blocks, 0 = 2-word blocks). A block starts (`blk_start` pulses and `busy` rises on the next cycle) only when all of the following hold: the block is enabled, it is idle, the input FIFO holds at least N words, and the result FIFO has at least N free words, where N is the block size in words.
- R5: Once started, the block offers exactly N input words to the core, oldest first, with `cin_last` marking the N-th. It accepts exactly N result words through `cout_valid`/`cout_ready`. `busy` falls on the cycle after the last result word is taken.
- R6: A bus read of address 1 pops the oldest result word. That word appears on `bus_rdata` on the cycle after the read.
- R7: A read of address 1 while the result FIFO is empty returns 0, pops nothing and sets the sticky flag `err_unf`.
- R8: A read of address 0 while the block is disabled and idle pops and returns the oldest input word. If the input FIFO is empty, the read returns 0. While the block is enabled or busy, the read returns 0 and pops nothing.
- R9: After any address-0 read that pops a word, no block starts until a flush is done.
- R10: Writing 1 to control bit 2 empties both FIFOs in that cycle. It also clears both error flags and the pending-flush condition, and aborts a running block. The bit always reads back as 0.
- R11: A result-FIFO pop by the bus and a result-word push from the core in the same cycle both take effect. No word is lost and no underflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 2 | Bus word address: 0 data-in, 1 data-out, 2 control |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| blk_start | output | 1 | One-cycle pulse when a block starts |
| busy | output | 1 | A block is in flight |
| cin_valid | output | 1 | Input word offered to the core |
| cin_ready | input | 1 | Core accepts the input word |
| cin_data | output | 32 | Input word to the core |
| cin_last | output | 1 | Final input word of the block |
| cout_valid | input | 1 | Core offers a result word |
| cout_ready | output | 1 | Block accepts a result word |
| cout_data | input | 32 | Result word from the core |
| in_empty | output | 1 | Input FIFO empty |
| in_full | output | 1 | Input FIFO full |
| out_empty | output | 1 | Result FIFO empty |
| out_full | output | 1 | Result FIFO full |
| err_ovf | output | 1 | Sticky: write to full input FIFO |
| err_unf | output | 1 | Sticky: read of empty result FIFO |

## Verification
The result FIFO can receive a word from the core and lose a word to a bus read in the same cycle. To force this overlap, the bench core holds back its results for a block while earlier words are still in the result FIFO. It then releases the results at the same time as a burst of back-to-back data-out reads. The scoreboard checks that every word arrives in order. The bench also checks that the FIFO ends empty with `err_unf` still clear, which shows that no pop was counted against an empty FIFO and no push was dropped.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  typedef enum logic [1:0] {
    A_DIN  = 2'd0,
    A_DOUT = 2'd1,
    A_CTRL = 2'd2,
    A_RSVD = 2'd3
  } cdf_addr_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_WIDE  = 1;
  localparam int CTL_FLUSH = 2;
endpackage

// File: rtl/cdf_fifo.sv
// Synchronous FIFO with occupancy count and single-cycle flush.
// DEPTH must be a power of two (pointers wrap naturally).
module cdf_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop  && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= wdata;
  end

  assign head  = mem[rptr];
  assign count = cnt;
endmodule

// File: rtl/cdf_seq.sv
// Block sequencer: start decision, input streaming and result collection.
module cdf_seq #(
  parameter int DEPTH  = 8,
  parameter int NARROW = 2,
  parameter int WIDE   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       en,
  input  logic                       mode_wide,
  input  logic                       hold,
  input  logic [$clog2(DEPTH+1)-1:0] in_cnt,
  input  logic [$clog2(DEPTH+1)-1:0] out_cnt,
  input  logic                       cin_ready,
  input  logic                       cout_valid,
  output logic                       start,
  output logic                       busy,
  output logic                       cin_valid,
  output logic                       cin_last,
  output logic                       cout_ready
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] blk_n, out_free, send_left, recv_left;
  logic          busy_q;

  assign blk_n    = mode_wide ? CW'(WIDE) : CW'(NARROW);
  assign out_free = CW'(DEPTH) - out_cnt;
  assign start    = en && !busy_q && !hold && !flush &&
                    (in_cnt >= blk_n) && (out_free >= blk_n);

  assign cin_valid  = busy_q && (send_left != '0);
  assign cin_last   = cin_valid && (send_left == CW'(1));
  assign cout_ready = busy_q && (recv_left != '0);
  assign busy       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      send_left <= '0;
      recv_left <= '0;
    end else if (flush) begin
      busy_q    <= 1'b0;
      send_left <= '0;
      recv_left <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      send_left <= blk_n;
      recv_left <= blk_n;
    end else begin
      if (cin_valid && cin_ready) send_left <= send_left - 1'b1;
      if (cout_valid && cout_ready) begin
        recv_left <= recv_left - 1'b1;
        if (recv_left == CW'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdf_stage.sv
module cdf_stage #(
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter int NARROW = 2,
  parameter int WIDE   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          blk_start,
  output logic          busy,
  output logic          cin_valid,
  input  logic          cin_ready,
  output logic [DW-1:0] cin_data,
  output logic          cin_last,
  input  logic          cout_valid,
  output logic          cout_ready,
  input  logic [DW-1:0] cout_data,
  output logic          in_empty,
  output logic          in_full,
  output logic          out_empty,
  output logic          out_full,
  output logic          err_ovf,
  output logic          err_unf
);
  import cdf_pkg::*;

  localparam int CW = $clog2(DEPTH+1);

  logic          en_q, wide_q, need_flush_q, ovf_q, unf_q;
  logic          wr_din, wr_ctrl, rd_din, rd_dout, flush;
  logic          in_push, in_pop, drain, core_take;
  logic          out_push, out_pop;
  logic [CW-1:0] in_cnt, out_cnt;
  logic [DW-1:0] in_head, out_head, ctrl_word;
  logic [DW-1:0] rdata_q;

  // bus decode
  assign wr_din  = bus_wr && (bus_addr == A_DIN);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign rd_din  = bus_rd && (bus_addr == A_DIN);
  assign rd_dout = bus_rd && (bus_addr == A_DOUT);
  assign flush   = wr_ctrl && bus_wdata[CTL_FLUSH];

  assign in_empty  = (in_cnt == '0);
  assign in_full   = (in_cnt == CW'(DEPTH));
  assign out_empty = (out_cnt == '0);
  assign out_full  = (out_cnt == CW'(DEPTH));

  // input side: bus pushes, core or drain pops
  assign in_push   = wr_din && !in_full;
  assign core_take = cin_valid && cin_ready;
  assign drain     = rd_din && !en_q && !busy && !in_empty;
  assign in_pop    = core_take || drain;

  // output side: core pushes, bus pops
  assign out_push = cout_valid && cout_ready;
  assign out_pop  = rd_dout && !out_empty;

  cdf_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_in_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (in_push),
    .wdata (bus_wdata),
    .pop   (in_pop),
    .head  (in_head),
    .count (in_cnt)
  );

  cdf_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_out_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (out_push),
    .wdata (cout_data),
    .pop   (out_pop),
    .head  (out_head),
    .count (out_cnt)
  );

  cdf_seq #(.DEPTH(DEPTH), .NARROW(NARROW), .WIDE(WIDE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .en         (en_q),
    .mode_wide  (wide_q),
    .hold       (need_flush_q),
    .in_cnt     (in_cnt),
    .out_cnt    (out_cnt),
    .cin_ready  (cin_ready),
    .cout_valid (cout_valid),
    .start      (blk_start),
    .busy       (busy),
    .cin_valid  (cin_valid),
    .cin_last   (cin_last),
    .cout_ready (cout_ready)
  );

  assign cin_data = in_head;

  // control and sticky state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      wide_q       <= 1'b0;
      need_flush_q <= 1'b0;
      ovf_q        <= 1'b0;
      unf_q        <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[CTL_EN];
        wide_q <= bus_wdata[CTL_WIDE];
      end
      if (flush) begin
        need_flush_q <= 1'b0;
        ovf_q        <= 1'b0;
        unf_q        <= 1'b0;
      end else begin
        if (drain)                need_flush_q <= 1'b1;
        if (wr_din && in_full)    ovf_q        <= 1'b1;
        if (rd_dout && out_empty) unf_q        <= 1'b1;
      end
    end
  end

  assign err_ovf = ovf_q;
  assign err_unf = unf_q;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CTL_EN]   = en_q;
    ctrl_word[CTL_WIDE] = wide_q;
  end

  // registered read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_DIN:   rdata_q <= drain   ? in_head  : '0;
        A_DOUT:  rdata_q <= out_pop ? out_head : '0;
        A_CTRL:  rdata_q <= ctrl_word;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/cdf_stage_chk.sv
module cdf_stage_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          blk_start,
  input logic          busy,
  input logic          cin_valid,
  input logic          in_empty,
  input logic          in_full,
  input logic          out_empty,
  input logic          err_ovf,
  input logic          err_unf
);
  logic flush_wr;
  assign flush_wr = bus_wr && (bus_addr == 2'd2) && bus_wdata[2];

  // R2
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_empty && in_full));

  // R3
  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && in_full) |=> err_ovf);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovf && !flush_wr) |=> err_ovf);

  // R5
  a_r5_start_then_stream: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> (busy && cin_valid));

  // R7
  a_r7_unf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1 && out_empty && !flush_wr) |=> (err_unf && bus_rdata == '0));

  // R8
  a_r8_din_busy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && busy) |=> (bus_rdata == '0));

  // R10
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> (in_empty && out_empty && !busy && !err_ovf && !err_unf));
endmodule

bind cdf_stage cdf_stage_chk #(.DW(DW)) chk_i (.*);

// File: tb/cdf_stage_tb_top.sv
`timescale 1ns/1ps
module cdf_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        blk_start, busy;
  logic        cin_valid, cin_ready, cin_last;
  logic [31:0] cin_data;
  logic        cout_valid, cout_ready;
  logic [31:0] cout_data;
  logic        in_empty, in_full, out_empty, out_full, err_ovf, err_unf;

  always #4 clk = ~clk;

  cdf_stage dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .blk_start(blk_start), .busy(busy), .cin_valid(cin_valid),
    .cin_ready(cin_ready), .cin_data(cin_data), .cin_last(cin_last),
    .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_data(cout_data),
    .in_empty(in_empty), .in_full(in_full), .out_empty(out_empty),
    .out_full(out_full), .err_ovf(err_ovf), .err_unf(err_unf)
  );

  int nchk = 0, nfail = 0, nstart = 0, cin_cnt = 0, cur_n = 2;
  logic [31:0] exp_q[$];
  logic [31:0] core_q[$];
  bit hold_ret = 1'b0;
  logic dout_rd_q = 1'b0;
  bit done = 1'b0;

  function automatic logic [31:0] xform(input logic [31:0] w);
    return {w[15:0], w[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input bit track);
    wr(2'd0, d);
    if (track) exp_q.push_back(xform(d));
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic setctl(input bit en, input bit wide, input bit fl);
    wr(2'd2, {29'd0, fl, wide, en});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // core model: accepts input words, returns transformed words
  always @(posedge clk) begin
    if (rst_n) begin
      if (blk_start) nstart++;
      if (cout_valid && cout_ready) void'(core_q.pop_front());
      if (cin_valid && cin_ready) begin
        core_q.push_back(cin_data);
        cin_cnt++;
        if (cin_last) begin
          chk("R5 words per block", cin_cnt, cur_n);
          cin_cnt = 0;
        end
      end
    end
  end

  initial begin
    cout_valid = 1'b0;
    cout_data  = '0;
    forever begin
      @(negedge clk);
      cout_valid = !hold_ret && (core_q.size() > 0);
      cout_data  = cout_valid ? xform(core_q[0]) : '0;
    end
  end

  // scoreboard monitor on result reads
  always @(posedge clk) dout_rd_q <= bus_rd && (bus_addr == 2'd1) && !out_empty;

  initial forever begin
    @(negedge clk);
    if (dout_rd_q) begin
      if (exp_q.size() == 0) chk("R6 unexpected result word", bus_rdata, 32'hDEAD_DEAD);
      else chk("R6 scoreboard order", bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int s0;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; cin_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 in_empty", in_empty, 1);
    chk("R1 out_empty", out_empty, 1);
    chk("R1 in_full", in_full, 0);
    chk("R1 busy", busy, 0);
    chk("R1 errors", {err_ovf, err_unf}, 0);
    chk("R1 rdata", bus_rdata, 0);

    // R4 narrow mode start needs 2 words
    setctl(1, 0, 0); cur_n = 2;
    push(32'h1111_0001, 1); idle(4);
    chk("R4 no start with 1 word", nstart, 0);
    push(32'h1111_0002, 1); idle(10);
    chk("R4 narrow start", nstart, 1);
    chk("R5 busy cleared", busy, 0);
    rd(2'd1, v); rd(2'd1, v);
    rd(2'd1, v);
    chk("R7 empty read value", v, 0);
    chk("R7 err_unf", err_unf, 1);

    // R4 wide mode needs 4 words
    setctl(1, 1, 0); cur_n = 4;
    for (int i = 0; i < 3; i++) push(32'h2222_0000 + i, 1);
    idle(6);
    chk("R4 no start with 3 words wide", nstart, 1);
    push(32'h2222_0003, 1); idle(12);
    chk("R4 wide start", nstart, 2);
    for (int i = 0; i < 4; i++) rd(2'd1, v);
    chk("R6 drained", out_empty, 1);

    // R4 output-space condition
    setctl(1, 0, 0); cur_n = 2;
    for (int i = 0; i < 8; i++) push(32'h3333_0000 + i, 1);
    idle(20);
    chk("R4 result fifo full", out_full, 1);
    chk("R4 four blocks", nstart, 6);
    push(32'h3333_0008, 1); push(32'h3333_0009, 1); idle(8);
    chk("R4 blocked by no space", nstart, 6);
    chk("R4 input held", in_empty, 0);
    rd(2'd1, v); idle(6);
    chk("R4 blocked by one free", nstart, 6);
    rd(2'd1, v); idle(10);
    chk("R4 starts with two free", nstart, 7);
    for (int i = 0; i < 8; i++) rd(2'd1, v);
    chk("R6 empty after reads", out_empty, 1);

    // R11 simultaneous push and pop on result FIFO
    setctl(1, 1, 1); cur_n = 4;
    chk("R10 flush clears unf", err_unf, 0);
    for (int i = 0; i < 4; i++) push(32'h4444_0000 + i, 1);
    idle(12);
    hold_ret = 1'b1;
    for (int i = 0; i < 4; i++) push(32'h5555_0000 + i, 1);
    idle(8);
    chk("R5 busy while results owed", busy, 1);
    hold_ret = 1'b0;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 2'd1;
    idle(8);
    bus_rd = 1'b0;
    idle(2);
    chk("R11 result fifo empty", out_empty, 1);
    chk("R11 no underflow", err_unf, 0);
    chk("R11 busy cleared", busy, 0);

    // R2 R3 R8 R9 drain path
    setctl(0, 0, 0); cur_n = 2;
    for (int i = 0; i < 8; i++) push(32'h6666_0000 + i, 0);
    chk("R2 in_full", in_full, 1);
    push(32'h6666_0099, 0);
    chk("R3 err_ovf", err_ovf, 1);
    chk("R3 still full", in_full, 1);
    for (int i = 0; i < 8; i++) begin
      rd(2'd0, v);
      chk("R8 drain order", v, 32'h6666_0000 + i);
    end
    rd(2'd0, v);
    chk("R8 empty drain value", v, 0);
    chk("R8 in_empty", in_empty, 1);
    push(32'h7777_0000, 0);
    setctl(1, 0, 0);
    rd(2'd0, v);
    chk("R8 enabled read value", v, 0);
    chk("R8 enabled read no pop", in_empty, 0);
    s0 = nstart;
    push(32'h7777_0001, 0); idle(6);
    chk("R9 no start before flush", nstart, s0);
    setctl(1, 0, 1);
    chk("R10 in_empty", in_empty, 1);
    chk("R10 err_ovf cleared", err_ovf, 0);
    rd(2'd2, v);
    chk("R10 ctrl readback", v, 32'h1);
    push(32'h8888_0000, 1); push(32'h8888_0001, 1); idle(10);
    chk("R9 start after flush", nstart, s0 + 1);
    rd(2'd1, v); rd(2'd1, v);

    // R10 abort in-flight block
    hold_ret = 1'b1;
    push(32'h9999_0000, 0); push(32'h9999_0001, 0); idle(8);
    chk("R10 busy before flush", busy, 1);
    setctl(1, 0, 1);
    core_q.delete();
    chk("R10 busy aborted", busy, 0);
    chk("R10 out_empty", out_empty, 1);
    hold_ret = 1'b0;
    idle(4);
    chk("R10 no late result", out_empty, 1);
    chk("R6 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule